// File: doc/BRIEF.md
# Packed Subword Saturating ALU

This block is a register-to-register arithmetic unit. It treats each 64-bit operand as four 16-bit integer lanes that work independently of each other. Every lane runs the same operation at the same time: an add, a subtract, a left shift or a right shift. Add and subtract take one of three overflow policies. The first is wraparound. The second clamps to the signed 16-bit range. The third clamps to the unsigned 16-bit range.

A carry or borrow never crosses from one lane into the next. A shift discards the bits that leave a lane, and they never enter a neighbouring lane. When the valid input is high, the lane results are captured into one output register, so each result appears exactly one clock after its operands. The lane width, the lane count and the adder structure are all parameters.

Top module: `psalu_top`

## Requirements
- R1: Lane i occupies bits [16i+15:16i] of each operand and of the result. A carry, borrow or shifted-out bit never moves from one lane into another, so 0x0000FFFF + 0x00000001 in wraparound mode gives 0x0000000000000000.
- R2: With op_sel 00 (add) or 01 (subtract) and mode_sel 00 (wraparound) or 11 (treated as wraparound), each lane result is the sum or difference modulo 65536.
- R3: With mode_sel 01 (signed saturation), an add or subtract lane result above 32767 becomes 0x7FFF, and one below -32768 becomes 0x8000.
- R4: With mode_sel 10 (unsigned saturation), an add that exceeds 65535 becomes 0xFFFF, and a subtract that goes below zero becomes 0x0000.
- R5: With op_sel 10, each lane is shifted left logically by shamt (0 to 15), with zeros filled in from the right. mode_sel has no effect on this operation.
- R6: With op_sel 11, each lane is shifted right by shamt. mode_sel bit 0 = 0 fills zeros (logical shift). mode_sel bit 0 = 1 copies the lane's sign bit (arithmetic shift).
- R7: A result computed from the inputs present at a rising edge where in_valid is 1 appears on result after that edge. This is a latency of exactly one cycle.
- R8: At an edge where in_valid is 0 and rst is 0, result keeps its value.
- R9: A synchronous active-high rst clears result to zero, and rst takes priority over in_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture enable for a new result |
| op_sel | input | 2 | 00 add, 01 subtract, 10 shift left, 11 shift right |
| mode_sel | input | 2 | 00 wrap, 01 signed saturate, 10 unsigned saturate, 11 wrap; bit 0 selects arithmetic right shift |
| shamt | input | 4 | Shift amount, applied to every lane |
| opnd_a | input | 64 | First packed operand |
| opnd_b | input | 64 | Second packed operand (add and subtract only) |
| result | output | 64 | Registered packed result |

## Verification
Every result is due on the first rising edge after the inputs are presented with in_valid high, because the only register on the path is the output register. The bench drives each input set on a falling edge and compares the result on the next falling edge. That falling edge comes after exactly one capturing edge and before the next. Hold is checked by leaving in_valid low across two edges while the operands change, and reset clearing is checked one edge after rst is raised.

// File: rtl/psalu_pkg.sv
package psalu_pkg;

   typedef enum logic [1:0] {
      OP_ADD = 2'b00,
      OP_SUB = 2'b01,
      OP_SHL = 2'b10,
      OP_SHR = 2'b11
   } psalu_op_e;

   typedef enum logic [1:0] {
      MODE_WRAP = 2'b00,
      MODE_SSAT = 2'b01,
      MODE_USAT = 2'b10,
      MODE_RSVD = 2'b11
   } psalu_mode_e;

endpackage

// File: rtl/psalu_addsub.sv
// One lane of add/subtract with overflow policy selection.
module psalu_addsub #(
   parameter int LANE_W       = 16,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [LANE_W-1:0] a,
   input  logic [LANE_W-1:0] b,
   input  logic              sub,
   input  logic [1:0]        mode,
   output logic [LANE_W-1:0] y
);
   localparam int MSB = LANE_W - 1;
   localparam logic [LANE_W-1:0] SMAX = {1'b0, {(LANE_W-1){1'b1}}};
   localparam logic [LANE_W-1:0] SMIN = {1'b1, {(LANE_W-1){1'b0}}};
   localparam logic [LANE_W-1:0] UMAX = {LANE_W{1'b1}};
   localparam logic [LANE_W-1:0] UMIN = '0;

   logic [LANE_W-1:0] raw;
   logic              uflag;   // unsigned carry-out (add) or borrow (sub)
   logic              sflag;   // signed overflow

   if (SHARED_ADDER) begin : g_shared
      logic [LANE_W-1:0] bx;
      logic [LANE_W:0]   full;
      always_comb begin
         bx    = sub ? ~b : b;
         full  = {1'b0, a} + {1'b0, bx} + {{LANE_W{1'b0}}, sub};
         raw   = full[MSB:0];
         uflag = sub ? ~full[LANE_W] : full[LANE_W];
         sflag = (a[MSB] == bx[MSB]) && (raw[MSB] != a[MSB]);
      end
   end else begin : g_split
      logic [LANE_W:0] s_add;
      logic [LANE_W:0] s_sub;
      always_comb begin
         s_add = {1'b0, a} + {1'b0, b};
         s_sub = {1'b0, a} - {1'b0, b};
         raw   = sub ? s_sub[MSB:0] : s_add[MSB:0];
         uflag = sub ? s_sub[LANE_W] : s_add[LANE_W];
         if (sub) sflag = (a[MSB] != b[MSB]) && (raw[MSB] != a[MSB]);
         else     sflag = (a[MSB] == b[MSB]) && (raw[MSB] != a[MSB]);
      end
   end

   always_comb begin
      unique case (mode)
         psalu_pkg::MODE_SSAT: y = sflag ? (a[MSB] ? SMIN : SMAX) : raw;
         psalu_pkg::MODE_USAT: y = uflag ? (sub ? UMIN : UMAX) : raw;
         default:              y = raw;
      endcase
   end
endmodule

// File: rtl/psalu_shift.sv
// One lane of logarithmic shifting; left shifts reuse the right-shift
// chain by mirroring the lane on the way in and out.
module psalu_shift #(
   parameter int LANE_W  = 16,
   parameter int SHAMT_W = 4
) (
   input  logic [LANE_W-1:0]  a,
   input  logic [SHAMT_W-1:0] shamt,
   input  logic               right,
   input  logic               arith,
   output logic [LANE_W-1:0]  y
);
   localparam int MSB = LANE_W - 1;

   logic [LANE_W-1:0] mirrored_in;
   logic [LANE_W-1:0] mirrored_out;
   logic              fill;
   logic [LANE_W-1:0] stage [SHAMT_W+1];

   always_comb begin
      for (int i = 0; i < LANE_W; i++) mirrored_in[i] = a[MSB-i];
      fill = right & arith & a[MSB];
   end

   assign stage[0] = right ? a : mirrored_in;

   for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
      localparam int STEP = 1 << k;
      if (STEP < LANE_W) begin : g_part
         assign stage[k+1] = shamt[k] ? {{STEP{fill}}, stage[k][MSB:STEP]} : stage[k];
      end else begin : g_full
         assign stage[k+1] = shamt[k] ? {LANE_W{fill}} : stage[k];
      end
   end

   always_comb begin
      for (int i = 0; i < LANE_W; i++) mirrored_out[i] = stage[SHAMT_W][MSB-i];
      y = right ? stage[SHAMT_W] : mirrored_out;
   end
endmodule

// File: rtl/psalu_lane.sv
// One complete lane: arithmetic path, shift path and the op select.
module psalu_lane #(
   parameter int LANE_W       = 16,
   parameter int SHAMT_W      = 4,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [LANE_W-1:0]   a,
   input  logic [LANE_W-1:0]   b,
   input  psalu_pkg::psalu_op_e op,
   input  logic [1:0]          mode,
   input  logic [SHAMT_W-1:0]  shamt,
   output logic [LANE_W-1:0]   y
);
   logic [LANE_W-1:0] y_arith;
   logic [LANE_W-1:0] y_shift;

   psalu_addsub #(.LANE_W(LANE_W), .SHARED_ADDER(SHARED_ADDER)) addsub_i (
      .a    (a),
      .b    (b),
      .sub  (op == psalu_pkg::OP_SUB),
      .mode (mode),
      .y    (y_arith)
   );

   psalu_shift #(.LANE_W(LANE_W), .SHAMT_W(SHAMT_W)) shift_i (
      .a     (a),
      .shamt (shamt),
      .right (op == psalu_pkg::OP_SHR),
      .arith (mode[0]),
      .y     (y_shift)
   );

   always_comb begin
      unique case (op)
         psalu_pkg::OP_ADD, psalu_pkg::OP_SUB: y = y_arith;
         default:                              y = y_shift;
      endcase
   end
endmodule

// File: rtl/psalu_top.sv
module psalu_top #(
   parameter int LANE_W       = 16,
   parameter int NUM_LANES    = 4,
   parameter bit SHARED_ADDER = 1'b1,
   localparam int DATA_W      = LANE_W * NUM_LANES,
   localparam int SHAMT_W     = $clog2(LANE_W)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   input  logic [1:0]         op_sel,
   input  logic [1:0]         mode_sel,
   input  logic [SHAMT_W-1:0] shamt,
   input  logic [DATA_W-1:0]  opnd_a,
   input  logic [DATA_W-1:0]  opnd_b,
   output logic [DATA_W-1:0]  result
);
   if (LANE_W < 2 || (LANE_W & (LANE_W - 1)) != 0) begin : g_bad_lane_w
      $error("psalu_top: LANE_W must be a power of two of at least 2");
   end
   if (NUM_LANES < 1) begin : g_bad_lanes
      $error("psalu_top: NUM_LANES must be at least 1");
   end

   psalu_pkg::psalu_op_e op;
   logic [DATA_W-1:0]    lanes_next;

   assign op = psalu_pkg::psalu_op_e'(op_sel);

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      psalu_lane #(
         .LANE_W       (LANE_W),
         .SHAMT_W      (SHAMT_W),
         .SHARED_ADDER (SHARED_ADDER)
      ) lane_i (
         .a     (opnd_a[l*LANE_W +: LANE_W]),
         .b     (opnd_b[l*LANE_W +: LANE_W]),
         .op    (op),
         .mode  (mode_sel),
         .shamt (shamt),
         .y     (lanes_next[l*LANE_W +: LANE_W])
      );
   end

   always_ff @(posedge clk) begin
      if (rst)           result <= '0;
      else if (in_valid) result <= lanes_next;
   end
endmodule

// File: rtl/psalu_checker.sv
module psalu_checker #(
   parameter int LANE_W    = 16,
   parameter int NUM_LANES = 4,
   localparam int DATA_W   = LANE_W * NUM_LANES,
   localparam int SHAMT_W  = $clog2(LANE_W)
) (
   input logic               clk,
   input logic               rst,
   input logic               in_valid,
   input logic [1:0]         op_sel,
   input logic [1:0]         mode_sel,
   input logic [SHAMT_W-1:0] shamt,
   input logic [DATA_W-1:0]  opnd_a,
   input logic [DATA_W-1:0]  opnd_b,
   input logic [DATA_W-1:0]  result
);
   localparam int MSB = LANE_W - 1;

   assert_reset_clear_R9: assert property (@(posedge clk) rst |=> result == '0);

   assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(result));

   assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_sel == 2'b00 && mode_sel == 2'b00 && opnd_b == '0)
      |=> result == $past(opnd_a));

   assert_shl_zero_R5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_sel == 2'b10 && shamt == '0) |=> result == $past(opnd_a));

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane_chk
      assert_lsr_msb_R6: assert property (@(posedge clk) disable iff (rst)
         (in_valid && op_sel == 2'b11 && !mode_sel[0] && shamt != '0)
         |=> !result[l*LANE_W + MSB]);

      assert_usat_add_floor_R4: assert property (@(posedge clk) disable iff (rst)
         (in_valid && op_sel == 2'b00 && mode_sel == 2'b10)
         |=> result[l*LANE_W +: LANE_W] >= $past(opnd_a[l*LANE_W +: LANE_W]));

      assert_usat_sub_ceiling_R4: assert property (@(posedge clk) disable iff (rst)
         (in_valid && op_sel == 2'b01 && mode_sel == 2'b10)
         |=> result[l*LANE_W +: LANE_W] <= $past(opnd_a[l*LANE_W +: LANE_W]));

      assert_ssat_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
         (in_valid && op_sel == 2'b00 && mode_sel == 2'b01
          && !opnd_a[l*LANE_W + MSB] && !opnd_b[l*LANE_W + MSB])
         |=> !result[l*LANE_W + MSB]);
   end
endmodule

bind psalu_top psalu_checker #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) chk_i (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .op_sel   (op_sel),
   .mode_sel (mode_sel),
   .shamt    (shamt),
   .opnd_a   (opnd_a),
   .opnd_b   (opnd_b),
   .result   (result)
);

// File: tb/psalu_top_tb_top.sv
`timescale 1ns/1ps
module psalu_top_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [1:0]  op_sel = '0;
   logic [1:0]  mode_sel = '0;
   logic [3:0]  shamt = '0;
   logic [63:0] opnd_a = '0;
   logic [63:0] opnd_b = '0;
   logic [63:0] result;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;   // 50 MHz

   psalu_top dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
      .mode_sel(mode_sel), .shamt(shamt), .opnd_a(opnd_a),
      .opnd_b(opnd_b), .result(result)
   );

   function automatic logic [15:0] ref_lane(input logic [1:0] op, input logic [1:0] md,
                                            input int sh, input logic [15:0] a,
                                            input logic [15:0] b);
      int ua = a;
      int ub = b;
      int sa = a[15] ? ua - 65536 : ua;
      int sb = b[15] ? ub - 65536 : ub;
      int r;
      case (op)
         2'b00, 2'b01: begin
            if (md == 2'b01) begin
               r = (op == 2'b00) ? sa + sb : sa - sb;
               if (r > 32767) r = 32767;
               if (r < -32768) r = -32768;
            end else if (md == 2'b10) begin
               r = (op == 2'b00) ? ua + ub : ua - ub;
               if (r > 65535) r = 65535;
               if (r < 0) r = 0;
            end else begin
               r = (op == 2'b00) ? ua + ub : ua - ub;
            end
         end
         2'b10:   r = ua << sh;
         default: r = md[0] ? (sa >>> sh) : (ua >> sh);
      endcase
      return r[15:0];
   endfunction

   function automatic logic [63:0] ref_word(input logic [1:0] op, input logic [1:0] md,
                                            input int sh, input logic [63:0] a,
                                            input logic [63:0] b);
      logic [63:0] w;
      for (int l = 0; l < 4; l++)
         w[l*16 +: 16] = ref_lane(op, md, sh, a[l*16 +: 16], b[l*16 +: 16]);
      return w;
   endfunction

   function automatic string tag_of(input logic [1:0] op, input logic [1:0] md);
      if (op == 2'b10) return "R5";
      if (op == 2'b11) return "R6";
      if (md == 2'b01) return "R3";
      if (md == 2'b10) return "R4";
      return "R2";
   endfunction

   task automatic check(input string req, input logic [63:0] exp);
      n_checks++;
      if (result !== exp) begin
         n_fail++;
         $display("FAIL %s: result=%h expected=%h", req, result, exp);
      end
   endtask

   // drive at a falling edge, compare at the next falling edge (one capture)
   task automatic run_op(input logic [1:0] op, input logic [1:0] md, input int sh,
                         input logic [63:0] a, input logic [63:0] b, input string req);
      op_sel = op; mode_sel = md; shamt = sh[3:0];
      opnd_a = a;  opnd_b = b;   in_valid = 1'b1;
      @(negedge clk);
      check(req, ref_word(op, md, sh, a, b));
   endtask

   logic [15:0] pat [8];

   initial begin
      #(20ns * 150000);
      n_fail++;
      $display("FAIL watchdog: result=%h expected=run completion", result);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      pat[0] = 16'h0000; pat[1] = 16'h0001; pat[2] = 16'h7FFF; pat[3] = 16'h8000;
      pat[4] = 16'h8001; pat[5] = 16'hFFFF; pat[6] = 16'h1234; pat[7] = 16'hC000;

      repeat (3) @(negedge clk);
      check("R9", 64'h0);   // reset state
      rst = 1'b0;

      // R1 lane boundary carry cases
      run_op(2'b00, 2'b00, 0, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0001, "R1");
      run_op(2'b00, 2'b10, 0, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0001, "R1");
      run_op(2'b01, 2'b00, 0, 64'h0001_0000_0000_0000, 64'h0000_0000_0000_0001, "R1");
      run_op(2'b10, 2'b00, 1, 64'h8000_8000_8000_8000, 64'h0, "R1");
      check("R1", 64'h0);
      run_op(2'b11, 2'b00, 1, 64'h0001_0001_0001_0001, 64'h0, "R1");
      check("R1", 64'h0);
      // saturation extremes
      run_op(2'b00, 2'b01, 0, {4{16'h7FFF}}, {4{16'h0001}}, "R3");
      check("R3", {4{16'h7FFF}});
      run_op(2'b01, 2'b01, 0, {4{16'h8000}}, {4{16'h0001}}, "R3");
      check("R3", {4{16'h8000}});
      run_op(2'b01, 2'b10, 0, {4{16'h0000}}, {4{16'h0001}}, "R4");
      check("R4", 64'h0);
      run_op(2'b00, 2'b11, 0, {4{16'hFFFF}}, {4{16'h0002}}, "R2");
      check("R2", {4{16'h0001}});
      run_op(2'b11, 2'b01, 15, {4{16'h8000}}, 64'h0, "R6");
      check("R6", {4{16'hFFFF}});

      // R7: result present exactly one capture later
      run_op(2'b00, 2'b00, 0, 64'h0004_0003_0002_0001, 64'h0010_0010_0010_0010, "R7");
      check("R7", 64'h0014_0013_0012_0011);

      // R8: hold with in_valid low while inputs change
      in_valid = 1'b0; opnd_a = '1; opnd_b = '1; op_sel = 2'b01;
      @(negedge clk); @(negedge clk);
      check("R8", 64'h0014_0013_0012_0011);

      // sweep ops x modes x lane-pattern combinations
      for (int op = 0; op < 4; op++)
         for (int md = 0; md < 4; md++)
            for (int ia = 0; ia < 8; ia++)
               for (int ib = 0; ib < 8; ib++) begin
                  logic [63:0] a, b;
                  a = {pat[ia], pat[(ia+1)%8], pat[(ia+2)%8], pat[(ia+3)%8]};
                  b = {pat[ib], pat[(ib+3)%8], pat[(ib+5)%8], pat[(ib+6)%8]};
                  run_op(op[1:0], md[1:0], (ia*3 + ib) % 16, a, b,
                         tag_of(op[1:0], md[1:0]));
               end

      // every shift amount for both shift directions and all modes
      for (int sh = 0; sh < 16; sh++)
         for (int md = 0; md < 4; md++) begin
            run_op(2'b10, md[1:0], sh, 64'h8001_7FFF_1234_C000, 64'hFFFF, "R5");
            run_op(2'b11, md[1:0], sh, 64'h8001_7FFF_1234_C000, 64'hFFFF, "R6");
         end

      // R9: reset mid-run beats in_valid
      op_sel = 2'b00; mode_sel = 2'b00; opnd_a = {4{16'h1111}}; opnd_b = '0;
      in_valid = 1'b1; rst = 1'b1;
      @(negedge clk);
      check("R9", 64'h0);
      rst = 1'b0; in_valid = 1'b0;
      @(negedge clk);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule